// File: doc/BRIEF.md
# Capture/Reload Timer with Serial Bit-Clock Output

This block is a 16-bit up-counter paired with a 16-bit capture/reload register and an 8-bit control register. Software reaches all three over a byte-wide register port. The counter advances in one of two ways. In timer mode it steps on each cycle where the internal tick enable is high. In counter mode it steps on each falling edge of an external count pin. Both external pins are asynchronous. Each one passes through a two-flop synchronizer, and a falling edge is found by comparing successive synchronized samples.

The block runs in one of three modes. In auto-reload mode an overflow loads the counter from the capture/reload register. In capture mode an overflow wraps the counter to zero, and the external trigger pin copies the running count into the capture/reload register. In baud mode every overflow reloads the counter and emits a one-cycle pulse that the serial receiver, the serial transmitter, or both can use as a bit clock. In the two non-baud modes a falling edge on the trigger pin can also force a reload or a capture, provided software has enabled it.

The block only raises flags. Interrupt vectoring and the serial port lie outside it.

Top module: `cr_timer`

## Requirements
- R1: After reset every register reads 0x00, and `baud_o` and `irq_o` are low.
- R2: Register addresses are fixed. 0 is control, 1 and 2 are count low and high, 3 and 4 are capture/reload low and high. Any other address reads 0x00 and ignores writes. Control bit 7 is the overflow flag, 6 the trigger flag, 5 receive-clock select, 4 transmit-clock select, 3 trigger enable, 2 run, 1 counter select (1 = count pin edges), 0 capture select (1 = capture mode).
- R3: In timer mode, with run at 1, the count increments by one on each clock cycle where `tick_i` is high. With run at 0 the count holds.
- R4: In counter mode the count increments once per falling edge of `cnt_pin_i`. The new value is visible after the third rising clock edge following the pin's fall. Rising edges do not count.
- R5: An increment from 0xFFFF is an overflow. In auto-reload mode it loads the count from the capture/reload register; in capture mode it wraps the count to 0x0000. Outside baud mode it sets control bit 7.
- R6: The overflow and trigger flags are set only by hardware and cleared only by a software write. A hardware set in the same cycle as a control write leaves the flag at 1.
- R7: With trigger enable at 1 and not in baud mode, a falling edge of `trig_pin_i` sets control bit 6. In capture mode it copies the count into the capture/reload register; in auto-reload mode it loads the count from that register. It takes effect on the third clock edge after the pin falls.
- R8: Trigger-pin edges change nothing while trigger enable is 0, or while bit 5 or bit 4 is 1.
- R9: Baud mode is selected when bit 5 or bit 4 is 1. In baud mode an overflow reloads the count from the capture/reload register, `baud_o` is high for the single cycle after that edge, and bit 7 is not set.
- R10: `rx_clk_o` equals `baud_o` when bit 5 is 1, and `other_ovf_i` otherwise. `tx_clk_o` follows the same rule using bit 4.
- R11: `irq_o` is high whenever control bit 7 or bit 6 is 1.
- R12: A software write to a count byte takes precedence over any count change in the same cycle. The other count byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Internal count enable used in timer mode |
| cnt_pin_i | input | 1 | Asynchronous external count pin |
| trig_pin_i | input | 1 | Asynchronous external trigger pin |
| other_ovf_i | input | 1 | Overflow pulse from another timer, used as the alternative serial clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Combinational read data |
| baud_o | output | 1 | One-cycle pulse after each baud-mode overflow |
| rx_clk_o | output | 1 | Selected serial receive clock pulse |
| tx_clk_o | output | 1 | Selected serial transmit clock pulse |
| irq_o | output | 1 | High while either flag is set |

## Verification
The hardest situations to reach are the ones where an overflow meets something else in the same cycle. An overflow can coincide with a trigger edge that has crossed the three-stage synchronizer, with a software write to a count byte, or with a control write that changes mode. Random traffic seldom drives the count up to 0xFFFF, so the stimulus biases byte writes toward 0xFF for the high bytes and 0xF0 for the low bytes. Overflows then come every few dozen ticks. The pins are toggled at random so that trigger edges line up with these overflows. A lockstep model in the bench, written from the requirements, predicts every register and output on every cycle. Directed sequences fix the synchronizer latency and the baud-pulse cycle.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
package crt_pkg;
  // control register bit positions (software-visible layout)
  localparam int CB_OVF  = 7;
  localparam int CB_TRF  = 6;
  localparam int CB_RXS  = 5;
  localparam int CB_TXS  = 4;
  localparam int CB_TREN = 3;
  localparam int CB_RUN  = 2;
  localparam int CB_CNTR = 1;
  localparam int CB_CAPM = 0;

  typedef struct packed {
    logic baud;
    logic capture;
    logic reload;
  } crt_mode_t;

  function automatic crt_mode_t crt_decode(input logic [7:0] c);
    crt_mode_t m;
    m.baud    = c[CB_RXS] | c[CB_TXS];
    m.capture = !m.baud && c[CB_CAPM];
    m.reload  = !m.baud && !c[CB_CAPM];
    return m;
  endfunction

  // increment request for the selected count source
  function automatic logic crt_step(input logic [7:0] c, input logic tick, input logic pin_fall);
    return c[CB_RUN] && (c[CB_CNTR] ? pin_fall : tick);
  endfunction
endpackage

// File: rtl/crt_edge_sync.sv
`timescale 1ns/1ps
module crt_edge_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] fall_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign fall_o[i] = prev_q && !s2_q;

    // R4: one pin fall yields exactly one single-cycle event
    p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[i] |=> !fall_o[i]);
  end
endmodule

// File: rtl/crt_count_core.sv
`timescale 1ns/1ps
module crt_count_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  localparam int NB    = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              capm_i,
  input  logic              trg_i,
  input  logic [NB-1:0]     cnt_we_i,
  input  logic [NB-1:0]     cap_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              ovf_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, cap_q, cnt_hw, cnt_d, cap_d;
  logic any_cnt_we, any_cap_we, capture_evt;

  assign any_cnt_we  = |cnt_we_i;
  assign any_cap_we  = |cap_we_i;
  assign ovf_o       = inc_i && (cnt_q == MAXV);
  assign capture_evt = trg_i && capm_i;

  always_comb begin
    cnt_hw = cnt_q;
    if (trg_i && !capm_i)  cnt_hw = cap_q;
    else if (ovf_o)        cnt_hw = capm_i ? '0 : cap_q;
    else if (inc_i)        cnt_hw = cnt_q + CNT_W'(1);
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign cnt_d[b*DATA_W +: DATA_W] = any_cnt_we
      ? (cnt_we_i[b] ? wdata_i : cnt_q[b*DATA_W +: DATA_W])
      : cnt_hw[b*DATA_W +: DATA_W];
    assign cap_d[b*DATA_W +: DATA_W] = any_cap_we
      ? (cap_we_i[b] ? wdata_i : cap_q[b*DATA_W +: DATA_W])
      : (capture_evt ? cnt_q[b*DATA_W +: DATA_W] : cap_q[b*DATA_W +: DATA_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

  // R3: no increment, trigger or write leaves the count unchanged
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !trg_i && !any_cnt_we) |=> $stable(cnt_o));
  // R5: reload-type overflow loads the stored value
  p_reload_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !capm_i && !trg_i && !any_cnt_we) |=> cnt_o == $past(cap_o));
  // R5: capture-mode overflow returns to zero
  p_zero_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && capm_i && !any_cnt_we) |=> cnt_o == '0);
  // R7: trigger in capture mode snapshots the count
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_evt && !any_cap_we) |=> cap_o == $past(cnt_o));
  // R12: software byte write wins over counting
  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i[0] |=> cnt_o[DATA_W-1:0] == $past(wdata_i));
endmodule

// File: rtl/crt_ctrl.sv
`timescale 1ns/1ps
module crt_ctrl
  import crt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       ovf_evt_i,
  input  logic       trg_i,
  input  logic       other_ovf_i,
  output logic [7:0] ctrl_o,
  output crt_mode_t  mode_o,
  output logic       baud_o,
  output logic       rx_clk_o,
  output logic       tx_clk_o
);
  logic [7:0] ctrl_q, ctrl_d;
  logic       baud_q, ovf_set;

  assign mode_o  = crt_decode(ctrl_q);
  assign ovf_set = ovf_evt_i && !mode_o.baud;

  always_comb begin
    ctrl_d = wr_i ? wdata_i : ctrl_q;
    if (ovf_set) ctrl_d[CB_OVF] = 1'b1;
    if (trg_i)   ctrl_d[CB_TRF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      baud_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      baud_q <= ovf_evt_i && mode_o.baud;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign baud_o   = baud_q;
  assign rx_clk_o = ctrl_q[CB_RXS] ? baud_q : other_ovf_i;
  assign tx_clk_o = ctrl_q[CB_TXS] ? baud_q : other_ovf_i;

  // R6: flags persist until software writes
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_OVF] && !wr_i) |=> ctrl_q[CB_OVF]);
  p_trf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_TRF] && !wr_i) |=> ctrl_q[CB_TRF]);
  // R6: hardware set beats a simultaneous write
  p_hw_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_i && !mode_o.baud && wr_i) |=> ctrl_q[CB_OVF]);
  // R9: no overflow flag while clocking the serial port
  p_no_ovf_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o.baud && !wr_i && !ctrl_q[CB_OVF]) |=> !ctrl_q[CB_OVF]);
  // R9: baud overflow produces the pulse next cycle
  p_baud_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_i && mode_o.baud) |=> baud_o);
endmodule

// File: rtl/cr_timer.sv
`timescale 1ns/1ps
module cr_timer
  import crt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              other_ovf_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              baud_o,
  output logic              rx_clk_o,
  output logic              tx_clk_o,
  output logic              irq_o
);
  localparam int NB = CNT_W / DATA_W;

  logic [1:0]       pin_fall;
  logic             cnt_fall, trg_fall, inc, trg, ovf_evt, ctrl_wr;
  logic [NB-1:0]    cnt_we, cap_we;
  logic [7:0]       ctrl;
  logic [CNT_W-1:0] cnt, cap;
  crt_mode_t        mode;

  crt_edge_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({trig_pin_i, cnt_pin_i}),
    .fall_o(pin_fall)
  );
  assign cnt_fall = pin_fall[0];
  assign trg_fall = pin_fall[1];

  assign ctrl_wr = wr_en_i && (wr_addr_i == '0);
  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign cnt_we[b] = wr_en_i && (wr_addr_i == ADDR_W'(b + 1));
    assign cap_we[b] = wr_en_i && (wr_addr_i == ADDR_W'(NB + 1 + b));
  end

  assign inc = crt_step(ctrl, tick_i, cnt_fall);
  assign trg = trg_fall && ctrl[CB_TREN] && !mode.baud;

  crt_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .inc_i(inc), .capm_i(mode.capture), .trg_i(trg),
    .cnt_we_i(cnt_we), .cap_we_i(cap_we), .wdata_i(wr_data_i),
    .cnt_o(cnt), .cap_o(cap), .ovf_o(ovf_evt)
  );

  crt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_i(ctrl_wr), .wdata_i(wr_data_i[7:0]),
    .ovf_evt_i(ovf_evt), .trg_i(trg), .other_ovf_i(other_ovf_i),
    .ctrl_o(ctrl), .mode_o(mode),
    .baud_o(baud_o), .rx_clk_o(rx_clk_o), .tx_clk_o(tx_clk_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0) rd_data_o = DATA_W'(ctrl);
    for (int b = 0; b < NB; b++) begin
      if (rd_addr_i == ADDR_W'(b + 1))      rd_data_o = cnt[b*DATA_W +: DATA_W];
      if (rd_addr_i == ADDR_W'(NB + 1 + b)) rd_data_o = cap[b*DATA_W +: DATA_W];
    end
  end

  assign irq_o = ctrl[CB_OVF] | ctrl[CB_TRF];

  // R8: disabled or baud-mode triggers leave the trigger flag clear
  p_trig_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctrl[CB_TREN] || mode.baud) && !ctrl_wr && !ctrl[CB_TRF]) |=> !ctrl[CB_TRF]);
  // R11: interrupt line tracks the flags
  p_irq_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (ctrl[CB_OVF] || ctrl[CB_TRF]));
endmodule

// File: tb/cr_timer_bench.sv
`timescale 1ns/1ps
module cr_timer_bench;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       cnt_pin = 1'b1, trig_pin = 1'b1, oth = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data;
  wire        baud, rxc, txc, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cr_timer u_cr_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_pin_i(cnt_pin),
    .trig_pin_i(trig_pin), .other_ovf_i(oth), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .baud_o(baud), .rx_clk_o(rxc), .tx_clk_o(txc),
    .irq_o(irq)
  );

  // reference model, restated from the requirements
  logic [7:0]  m_ctrl = '0;
  logic [15:0] m_cnt = '0, m_cap = '0;
  logic        m_baud = 1'b0;
  logic [2:0]  m_cp = '0, m_tp = '0; // {prev, s2, s1}

  always @(posedge clk) begin : model
    logic cf, tf, bm, cm, step_en, ov, tg;
    logic [15:0] nc, np;
    logic [7:0]  nctl;
    if (!rst_n) begin
      m_ctrl <= '0; m_cnt <= '0; m_cap <= '0; m_baud <= 1'b0;
      m_cp <= '0; m_tp <= '0;
    end else begin
      cf = m_cp[2] & ~m_cp[1];
      tf = m_tp[2] & ~m_tp[1];
      bm = m_ctrl[5] | m_ctrl[4];
      cm = !bm && m_ctrl[0];
      step_en = m_ctrl[2] && (m_ctrl[1] ? cf : tick);
      ov = step_en && (m_cnt == 16'hFFFF);
      tg = tf && m_ctrl[3] && !bm;
      nc = m_cnt;
      if (wr_en && wr_addr == 3'd1)      nc[7:0]  = wr_data;
      else if (wr_en && wr_addr == 3'd2) nc[15:8] = wr_data;
      else if (tg && !cm)                nc = m_cap;
      else if (ov)                       nc = cm ? 16'h0 : m_cap;
      else if (step_en)                  nc = m_cnt + 16'd1;
      np = m_cap;
      if (wr_en && wr_addr == 3'd3)      np[7:0]  = wr_data;
      else if (wr_en && wr_addr == 3'd4) np[15:8] = wr_data;
      else if (tg && cm)                 np = m_cnt;
      nctl = (wr_en && wr_addr == 3'd0) ? wr_data : m_ctrl;
      if (ov && !bm) nctl[7] = 1'b1;
      if (tg)        nctl[6] = 1'b1;
      m_cnt <= nc; m_cap <= np; m_ctrl <= nctl;
      m_baud <= ov && bm;
      m_cp <= {m_cp[1], m_cp[0], cnt_pin};
      m_tp <= {m_tp[1], m_tp[0], trig_pin};
    end
  end

  function automatic logic [7:0] exp_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt[7:0];
      2: return m_cnt[15:8];
      3: return m_cap[7:0];
      4: return m_cap[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R6 control";
    if (a < 3)  return "R3 count";
    if (a < 5)  return "R7 capture-reload";
    return "R2 unmapped";
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int a = 0; a < 6; a++) begin
      rd_addr = 3'(a);
      #0.1;
      chk(tag_of(a), 16'(rd_data), 16'(exp_read(a)));
    end
    chk("R9 baud pulse", 16'(baud), 16'(m_baud));
    chk("R10 rx clock", 16'(rxc), 16'(m_ctrl[5] ? m_baud : oth));
    chk("R10 tx clock", 16'(txc), 16'(m_ctrl[4] ? m_baud : oth));
    chk("R11 irq", 16'(irq), 16'(m_ctrl[7] | m_ctrl[6]));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    rd_addr = a;
    #0.1;
    chk(tag, 16'(rd_data), 16'(e));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1: reset state
    for (int a = 0; a < 5; a++) expect_rd(3'(a), 8'h00, "R1 reset value");
    chk("R1 baud idle", 16'(baud), 16'h0);
    chk("R1 irq idle", 16'(irq), 16'h0);

    // R5: reload-mode overflow, R11 irq
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF); wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd0, 8'h04);
    tick = 1'b1; step();
    expect_rd(3'd1, 8'hFF, "R3 tick increment");
    step(); tick = 1'b0;
    expect_rd(3'd1, 8'h34, "R5 reload low");
    expect_rd(3'd2, 8'h12, "R5 reload high");
    expect_rd(3'd0, 8'h84, "R5 overflow flag");
    chk("R11 irq on flag", 16'(irq), 16'h1);
    step(); step();
    expect_rd(3'd0, 8'h84, "R6 flag sticky");
    wr(3'd0, 8'h00);
    expect_rd(3'd0, 8'h00, "R6 software clear");
    expect_rd(3'd7, 8'h00, "R2 unmapped address");

    // R7: trigger capture with latency of three edges
    wr(3'd1, 8'h00); wr(3'd2, 8'h01); wr(3'd0, 8'h09);
    trig_pin = 1'b0;
    step(); step();
    expect_rd(3'd3, 8'h34, "R7 no capture before sync");
    step();
    expect_rd(3'd3, 8'h00, "R7 captured low");
    expect_rd(3'd4, 8'h01, "R7 captured high");
    expect_rd(3'd0, 8'h49, "R7 trigger flag");
    trig_pin = 1'b1; repeat (3) step();

    // R8: trigger ignored with enable clear
    wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h02);
    trig_pin = 1'b0; repeat (4) step();
    expect_rd(3'd4, 8'h01, "R8 capture register kept");
    expect_rd(3'd0, 8'h01, "R8 no trigger flag");
    trig_pin = 1'b1; repeat (3) step();

    // R4: counter mode on falling pin edges
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h06);
    cnt_pin = 1'b0; step(); step();
    expect_rd(3'd1, 8'h00, "R4 before third edge");
    step();
    expect_rd(3'd1, 8'h01, "R4 counted fall");
    cnt_pin = 1'b1; repeat (3) step();
    expect_rd(3'd1, 8'h01, "R4 rise not counted");

    // R9/R10: baud mode overflow
    wr(3'd3, 8'hF0); wr(3'd4, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h24);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R9 baud pulse high", 16'(baud), 16'h1);
    chk("R10 rx follows baud", 16'(rxc), 16'h1);
    chk("R10 tx follows other", 16'(txc), 16'h0);
    expect_rd(3'd1, 8'hF0, "R9 baud reload");
    expect_rd(3'd0, 8'h24, "R9 no overflow flag");
    step();
    chk("R9 pulse one cycle", 16'(baud), 16'h0);

    // R12 then R3 run off
    wr(3'd0, 8'h04);
    tick = 1'b1;
    wr(3'd1, 8'h55);
    expect_rd(3'd1, 8'h55, "R12 write beats increment");
    expect_rd(3'd2, 8'hFF, "R12 other byte kept");
    step();
    expect_rd(3'd1, 8'h56, "R3 counting");
    wr(3'd0, 8'h00);
    step(); step();
    expect_rd(3'd1, 8'h57, "R3 held when stopped");
    tick = 1'b0;

    // random traffic against the model
    for (int i = 0; i < 20000; i++) begin
      logic [31:0] r;
      r = $urandom;
      tick = r[0];
      if (r[4:1] == 4'd0) cnt_pin = ~cnt_pin;
      if (r[9:5] == 5'd0) trig_pin = ~trig_pin;
      oth = (r[12:10] == 3'd0);
      if (r[15:13] == 3'd0) begin
        wr_en = 1'b1;
        wr_addr = 3'($urandom % 6);
        wr_data = 8'($urandom);
        if ((wr_addr == 3'd2 || wr_addr == 3'd4) && r[16]) wr_data = 8'hFF;
        if ((wr_addr == 3'd1 || wr_addr == 3'd3) && r[17]) wr_data = 8'hF0;
        if (wr_addr == 3'd0 && r[18]) wr_data[2] = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      step();
    end
    wr_en = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule